// File: doc/BRIEF.md
# Accumulator with Link Bit and Adder-Logic Stage

This block holds the working register of a small stored-program processor: an accumulator of `ACC_W` bits (16 by default) and a one-bit link flip-flop that extends it. A single adder-and-logic stage computes the accumulator's next value. The sequencer's strobes select the operation: three memory-operand opcode lines qualified by the fifth timing pulse, a register-operation strobe and an I/O strobe. The low twelve instruction bits then choose the operation, one bit per operation.

Memory-operand steps combine the data register with the accumulator. They can AND it in, add it with the carry going to the link, or copy it across. Register operations can clear or invert the accumulator or the link, increment the accumulator, or rotate the accumulator and link together as one loop of `ACC_W+1` bits. An I/O step copies a character of `CHAR_W` bits into the low end of the accumulator. Three status outputs feed the sequencer's skip tests: accumulator zero, accumulator sign, and link zero.

Top module: `acc_link_unit`

## Requirements
- R1: A synchronous active-high `rst` sets the accumulator and the link to 0 at the next rising clock edge.
- R2: With `t5` and `dec_and` high, the accumulator becomes accumulator AND `dr` at the clock edge.
- R3: With `t5` and `dec_add` high, the accumulator becomes the low `ACC_W` bits of accumulator + `dr`, and the link takes the carry out of the top bit.
- R4: With `t5` and `dec_lda` high, the accumulator is loaded with `dr`.
- R5: With `io_stb` and `ctrl[11]` high, the accumulator's low `CHAR_W` bits take `inpr`. Its upper bits and the link stay unchanged.
- R6: With `rr_stb` high, `ctrl[11]` clears the accumulator, `ctrl[10]` clears the link, `ctrl[9]` inverts every accumulator bit and `ctrl[8]` inverts the link.
- R7: With `rr_stb` and `ctrl[7]` high, the accumulator shifts right by one. Its top bit takes the old link, and the link takes the old bit 0.
- R8: With `rr_stb` and `ctrl[6]` high, the accumulator shifts left by one. Bit 0 takes the old link, and the link takes the old top bit.
- R9: With `rr_stb` and `ctrl[5]` high, the accumulator increments modulo 2^`ACC_W`. The link is unchanged and any carry out is dropped.
- R10: `acc_zero` is 1 exactly when the registered accumulator is 0. `acc_neg` equals its top bit. `link_zero` is 1 exactly when the link is 0.
- R11: When several operations are asserted, the accumulator follows the first one in this order: clear, increment, AND, add, load, character input, invert, rotate right, rotate left. The link follows link clear first, then link invert, then the carry or shifted-out bit of the selected add or rotate. Otherwise the link holds.
- R12: The accumulator and the link hold their values when no operation is selected. This covers `ctrl[4:0]` under `rr_stb`, any `ctrl` bit other than 11 under `io_stb`, and opcode lines while `t5` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dr | input | ACC_W | Memory operand from the data register |
| inpr | input | CHAR_W | Character from the input register |
| dec_and | input | 1 | Opcode line for AND with memory |
| dec_add | input | 1 | Opcode line for add with memory |
| dec_lda | input | 1 | Opcode line for load from memory |
| t5 | input | 1 | Timing pulse that qualifies the opcode lines |
| rr_stb | input | 1 | Register-operation strobe |
| io_stb | input | 1 | Input/output-operation strobe |
| ctrl | input | 12 | Low twelve instruction bits, one bit per operation |
| acc_q | output | ACC_W | Accumulator value |
| link_q | output | 1 | Link (extension) bit |
| acc_zero | output | 1 | Accumulator equals zero |
| acc_neg | output | 1 | Accumulator sign bit |
| link_zero | output | 1 | Link equals zero |

## Verification
The bench builds the unit with its default parameters, `ACC_W` = 16 and `CHAR_W` = 8. At these sizes the add carry out of bit 15, the increment wrap from 0xFFFF to 0, and 17-bit rotates that pass a bit through the link are all reachable from directed operands. The 8-bit character field leaves a visible upper byte, so the bench can confirm that a character input keeps that byte. A behavioural model of the accumulator and link runs next to the unit. The bench compares all outputs after every edge, both in the directed sequences and in a long run of random strobe and `ctrl` combinations that exercises the priority order.

// File: rtl/acc_link_pkg.sv
package acc_link_pkg;

    // Positions in the instruction's low field that select each operation
    localparam int unsigned CTRL_W      = 12;
    localparam int unsigned BIT_ZERO_AC = 11;
    localparam int unsigned BIT_ZERO_E  = 10;
    localparam int unsigned BIT_INV_AC  = 9;
    localparam int unsigned BIT_INV_E   = 8;
    localparam int unsigned BIT_ROR     = 7;
    localparam int unsigned BIT_ROL     = 6;
    localparam int unsigned BIT_INC     = 5;
    localparam int unsigned BIT_CHAR_IN = 11;

    typedef enum logic [3:0] {
        AOP_HOLD,
        AOP_ZERO,
        AOP_INC,
        AOP_AND,
        AOP_ADD,
        AOP_LOAD,
        AOP_CHAR,
        AOP_INV,
        AOP_ROR,
        AOP_ROL
    } acc_op_e;

    typedef struct packed {
        acc_op_e op;
        logic    e_zero;
        logic    e_flip;
    } acc_cmd_t;

endpackage

// File: rtl/acc_link_decode.sv
module acc_link_decode
    import acc_link_pkg::*;
(
    input  logic              t5,
    input  logic              dec_and,
    input  logic              dec_add,
    input  logic              dec_lda,
    input  logic              rr_stb,
    input  logic              io_stb,
    input  logic [CTRL_W-1:0] ctrl,
    output acc_cmd_t          cmd
);

    logic skip_bits_unused;
    assign skip_bits_unused = ^ctrl[4:0];

    always_comb begin
        cmd.op     = AOP_HOLD;
        cmd.e_zero = rr_stb & ctrl[BIT_ZERO_E];
        cmd.e_flip = rr_stb & ctrl[BIT_INV_E];
        if (rr_stb && ctrl[BIT_ZERO_AC])
            cmd.op = AOP_ZERO;
        else if (rr_stb && ctrl[BIT_INC])
            cmd.op = AOP_INC;
        else if (t5 && dec_and)
            cmd.op = AOP_AND;
        else if (t5 && dec_add)
            cmd.op = AOP_ADD;
        else if (t5 && dec_lda)
            cmd.op = AOP_LOAD;
        else if (io_stb && ctrl[BIT_CHAR_IN])
            cmd.op = AOP_CHAR;
        else if (rr_stb && ctrl[BIT_INV_AC])
            cmd.op = AOP_INV;
        else if (rr_stb && ctrl[BIT_ROR])
            cmd.op = AOP_ROR;
        else if (rr_stb && ctrl[BIT_ROL])
            cmd.op = AOP_ROL;
    end

endmodule

// File: rtl/acc_link_alu.sv
module acc_link_alu
    import acc_link_pkg::*;
#(
    parameter int unsigned ACC_W  = 16,
    parameter int unsigned CHAR_W = 8
) (
    input  acc_op_e           op,
    input  logic [ACC_W-1:0]  acc,
    input  logic              link,
    input  logic [ACC_W-1:0]  dr,
    input  logic [CHAR_W-1:0] chr,
    output logic [ACC_W-1:0]  acc_nxt,
    output logic              link_new,
    output logic              link_upd
);

    localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] chr_merged;

    assign sum = {1'b0, acc} + {1'b0, dr};

    generate
        if (CHAR_W < ACC_W) begin : g_narrow_char
            assign chr_merged = {acc[ACC_W-1:CHAR_W], chr};
        end else begin : g_full_char
            assign chr_merged = chr[ACC_W-1:0];
        end
    endgenerate

    always_comb begin
        acc_nxt  = acc;
        link_new = link;
        link_upd = 1'b0;
        unique case (op)
            AOP_ZERO: acc_nxt = '0;
            AOP_INC:  acc_nxt = acc + ONE;
            AOP_AND:  acc_nxt = acc & dr;
            AOP_ADD: begin
                acc_nxt  = sum[ACC_W-1:0];
                link_new = sum[ACC_W];
                link_upd = 1'b1;
            end
            AOP_LOAD: acc_nxt = dr;
            AOP_CHAR: acc_nxt = chr_merged;
            AOP_INV:  acc_nxt = ~acc;
            AOP_ROR: begin
                acc_nxt  = {link, acc[ACC_W-1:1]};
                link_new = acc[0];
                link_upd = 1'b1;
            end
            AOP_ROL: begin
                acc_nxt  = {acc[ACC_W-2:0], link};
                link_new = acc[ACC_W-1];
                link_upd = 1'b1;
            end
            default: acc_nxt = acc;
        endcase
    end

endmodule

// File: rtl/acc_link_state.sv
module acc_link_state #(
    parameter int unsigned ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc_d,
    input  logic             e_zero,
    input  logic             e_flip,
    input  logic             link_upd,
    input  logic             link_new,
    output logic [ACC_W-1:0] acc_q,
    output logic             link_q
);

    logic link_d;

    always_comb begin
        if (e_zero)
            link_d = 1'b0;
        else if (e_flip)
            link_d = ~link_q;
        else if (link_upd)
            link_d = link_new;
        else
            link_d = link_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            link_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            link_q <= link_d;
        end
    end

endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
    import acc_link_pkg::*;
#(
    parameter int unsigned ACC_W  = 16,
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  dr,
    input  logic [CHAR_W-1:0] inpr,
    input  logic              dec_and,
    input  logic              dec_add,
    input  logic              dec_lda,
    input  logic              t5,
    input  logic              rr_stb,
    input  logic              io_stb,
    input  logic [11:0]       ctrl,
    output logic [ACC_W-1:0]  acc_q,
    output logic              link_q,
    output logic              acc_zero,
    output logic              acc_neg,
    output logic              link_zero
);

    acc_cmd_t         cmd;
    logic [ACC_W-1:0] acc_nxt;
    logic             link_new;
    logic             link_upd;

    acc_link_decode u_dec (
        .t5      (t5),
        .dec_and (dec_and),
        .dec_add (dec_add),
        .dec_lda (dec_lda),
        .rr_stb  (rr_stb),
        .io_stb  (io_stb),
        .ctrl    (ctrl),
        .cmd     (cmd)
    );

    acc_link_alu #(.ACC_W(ACC_W), .CHAR_W(CHAR_W)) u_alu (
        .op       (cmd.op),
        .acc      (acc_q),
        .link     (link_q),
        .dr       (dr),
        .chr      (inpr),
        .acc_nxt  (acc_nxt),
        .link_new (link_new),
        .link_upd (link_upd)
    );

    acc_link_state #(.ACC_W(ACC_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .acc_d    (acc_nxt),
        .e_zero   (cmd.e_zero),
        .e_flip   (cmd.e_flip),
        .link_upd (link_upd),
        .link_new (link_new),
        .acc_q    (acc_q),
        .link_q   (link_q)
    );

    assign acc_zero  = ~|acc_q;
    assign acc_neg   = acc_q[ACC_W-1];
    assign link_zero = ~link_q;

endmodule

// File: rtl/acc_link_unit_chk.sv
module acc_link_unit_chk #(
    parameter int unsigned ACC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [ACC_W-1:0] dr,
    input logic             dec_and,
    input logic             dec_add,
    input logic             dec_lda,
    input logic             t5,
    input logic             rr_stb,
    input logic             io_stb,
    input logic [11:0]      ctrl,
    input logic [ACC_W-1:0] acc_q,
    input logic             link_q,
    input logic             acc_zero,
    input logic             acc_neg,
    input logic             link_zero
);

    logic mem_any;
    logic rr_any;
    logic idle;

    assign mem_any = t5 & (dec_and | dec_add | dec_lda);
    assign rr_any  = rr_stb & (|ctrl[11:5]);
    assign idle    = !mem_any && !rr_any && !(io_stb && ctrl[11]);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (acc_q == '0) && !link_q);  // R1

    AST_LOAD_TAKES_DR: assert property (@(posedge clk) disable iff (rst)
        (t5 && dec_lda && !dec_and && !dec_add && !rr_stb && !io_stb)
        |=> acc_q == $past(dr));  // R4

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (rr_stb && ctrl[11]) |=> acc_q == '0);  // R11

    AST_INC_KEEPS_LINK: assert property (@(posedge clk) disable iff (rst)
        (rr_stb && ctrl[5] && !ctrl[11] && !ctrl[10] && !ctrl[8])
        |=> link_q == $past(link_q));  // R9

    AST_ROL_LINK_FROM_TOP: assert property (@(posedge clk) disable iff (rst)
        (rr_stb && ctrl[6] && !ctrl[11] && !ctrl[10] && !ctrl[9] &&
         !ctrl[8] && !ctrl[7] && !ctrl[5] && !mem_any && !io_stb)
        |=> link_q == $past(acc_q[ACC_W-1]));  // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        idle |=> $stable(acc_q) && $stable(link_q));  // R12

    AST_FLAGS_AGREE: assert property (@(posedge clk) disable iff (rst)
        acc_zero |-> !acc_neg && (link_zero != link_q));  // R10

endmodule

bind acc_link_unit acc_link_unit_chk #(.ACC_W(ACC_W)) u_chk (.*);

// File: tb/acc_link_unit_test.sv
module acc_link_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] dr;
    logic [7:0]  inpr;
    logic        dec_and, dec_add, dec_lda, t5, rr_stb, io_stb;
    logic [11:0] ctrl;
    logic [15:0] acc_q;
    logic        link_q, acc_zero, acc_neg, link_zero;

    int unsigned tests = 0;
    int unsigned fails = 0;
    bit          done  = 1'b0;

    // behavioural model state
    int unsigned m_acc = 0;
    int unsigned m_e   = 0;

    always #5 clk = ~clk;

    acc_link_unit uut (
        .clk(clk), .rst(rst), .dr(dr), .inpr(inpr),
        .dec_and(dec_and), .dec_add(dec_add), .dec_lda(dec_lda),
        .t5(t5), .rr_stb(rr_stb), .io_stb(io_stb), .ctrl(ctrl),
        .acc_q(acc_q), .link_q(link_q), .acc_zero(acc_zero),
        .acc_neg(acc_neg), .link_zero(link_zero)
    );

    task automatic compare(input string req);
        bit ok;
        tests++;
        ok = (acc_q == m_acc[15:0]) && (link_q == m_e[0]) &&
             (acc_zero == (m_acc == 0)) && (acc_neg == m_acc[15]) &&
             (link_zero == (m_e == 0));
        if (!ok) begin
            fails++;
            $display("FAIL %s: acc=%h link=%b z=%b n=%b lz=%b expected acc=%h link=%0d z=%0d n=%0d lz=%0d",
                     req, acc_q, link_q, acc_zero, acc_neg, link_zero,
                     m_acc[15:0], m_e, m_acc == 0, m_acc[15], m_e == 0);
        end
    endtask

    task automatic model_step(input int unsigned d, input int unsigned ch,
                              input bit a0, input bit a1, input bit a2, input bit t,
                              input bit r, input bit pp, input logic [11:0] b);
        int unsigned nacc = m_acc;
        int unsigned ne   = m_e;
        int unsigned s;
        bit          e_src = 1'b0;
        int unsigned e_val = 0;
        if (r && b[11]) nacc = 0;
        else if (r && b[5]) nacc = (m_acc + 1) % 65536;
        else if (t && a0) nacc = m_acc & d;
        else if (t && a1) begin
            s = m_acc + d; nacc = s % 65536; e_src = 1; e_val = s / 65536;
        end
        else if (t && a2) nacc = d;
        else if (pp && b[11]) nacc = (m_acc / 256) * 256 + ch;
        else if (r && b[9]) nacc = 65535 - m_acc;
        else if (r && b[7]) begin
            nacc = m_acc / 2 + m_e * 32768; e_src = 1; e_val = m_acc % 2;
        end
        else if (r && b[6]) begin
            nacc = (m_acc * 2) % 65536 + m_e; e_src = 1; e_val = m_acc / 32768;
        end
        if (r && b[10]) ne = 0;
        else if (r && b[8]) ne = 1 - m_e;
        else if (e_src) ne = e_val;
        m_acc = nacc;
        m_e   = ne;
    endtask

    task automatic step(input string req, input logic [15:0] d, input logic [7:0] ch,
                        input bit a0, input bit a1, input bit a2, input bit t,
                        input bit r, input bit pp, input logic [11:0] b);
        @(negedge clk);
        dr = d; inpr = ch; dec_and = a0; dec_add = a1; dec_lda = a2;
        t5 = t; rr_stb = r; io_stb = pp; ctrl = b;
        model_step(d, ch, a0, a1, a2, t, r, pp, b);
        @(posedge clk);
        #1;
        compare(req);
    endtask

    task automatic load(input logic [15:0] v);
        step("R4", v, 8'h00, 0, 0, 1, 1, 0, 0, 12'h000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; dr = '0; inpr = '0; dec_and = 0; dec_add = 0; dec_lda = 0;
        t5 = 0; rr_stb = 0; io_stb = 0; ctrl = '0;
        repeat (2) @(posedge clk);
        #1;
        m_acc = 0; m_e = 0;
        compare("R1");
        @(negedge clk);
        rst = 1'b0;

        load(16'h1234);                                           // R4
        step("R2", 16'h0FF0, 8'h00, 1, 0, 0, 1, 0, 0, 12'h000);   // 0x0230
        load(16'h8001);
        step("R3", 16'h8001, 8'h00, 0, 1, 0, 1, 0, 0, 12'h000);   // 0x0002, carry 1
        step("R7", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h080);   // 0x8001, E 0
        step("R8", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h040);   // 0x0002, E 1
        step("R8", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h040);   // 0x0005, E 0
        step("R6", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h200);   // invert AC
        step("R6", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h100);   // invert E
        load(16'hFFFF);
        step("R9", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h020);   // wrap to 0, E stays 1
        step("R10", 16'h0000, 8'h00, 0, 0, 0, 0, 0, 0, 12'h000);  // zero flag, link set
        step("R6", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h400);   // clear E
        load(16'h8000);
        step("R10", 16'h0000, 8'h00, 0, 0, 0, 0, 0, 0, 12'h000);  // sign flag
        step("R6", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h800);   // clear AC
        load(16'hABCD);
        step("R5", 16'h0000, 8'h5A, 0, 0, 0, 0, 0, 1, 12'h800);   // 0xAB5A
        step("R12", 16'h0000, 8'h33, 0, 0, 0, 0, 0, 1, 12'h400);  // io without bit 11
        step("R12", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h01F);  // skip-test bits only
        step("R12", 16'h1111, 8'h00, 1, 1, 1, 0, 0, 0, 12'h000);  // opcode lines, t5 low
        step("R11", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h820);  // clear beats increment
        step("R11", 16'h7777, 8'h00, 0, 0, 1, 1, 1, 0, 12'h020);  // increment beats load
        load(16'hF000);
        step("R11", 16'hF000, 8'h00, 0, 1, 0, 1, 1, 0, 12'h400);  // E clear beats carry
        step("R11", 16'h0F0F, 8'h00, 1, 1, 1, 1, 0, 0, 12'h000);  // AND beats add/load
        step("R11", 16'h0000, 8'h00, 0, 0, 0, 0, 1, 0, 12'h2C0);  // invert beats rotates

        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv = $urandom;
            logic [11:0] b  = 12'($urandom) & ((rv[3:0] == 0) ? 12'hFFF : (12'h1 << (5 + rv[6:4] % 7)));
            step("R11", 16'($urandom), 8'($urandom), rv[8], rv[9], rv[10], rv[11],
                 rv[12] | rv[13], rv[14] & rv[15], b);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule